// File: doc/BRIEF.md
# Mode-Banked Register File

This block stores the general registers and status words of a 32-bit core that runs in several operating modes. Software addresses sixteen architectural registers with a 4-bit index. The physical storage behind an index depends on the mode held in the low five bits of the current status word (CPSR). Two combinational read ports and one write port all act in the current mode. The current status word can be read and written directly. The saved status word (SPSR) of the current mode can be read and written as well.

The current bank acts as the block's state. There are six states: BANK_USR, BANK_FIQ, BANK_IRQ, BANK_SVC, BANK_ABT and BANK_UND. Two transitions move between them. A CPSR write loads a new mode field. An exception entry does three things on one clock edge: it sets the mode field to a target mode, saves the old CPSR into that mode's SPSR, and writes a return address into that mode's link register (R14). Any unrecognised encoding stays in BANK_USR.

Top module: `rbank_regfile`

## Requirements
- R1: After reset all general registers and all saved status words read zero, and the CPSR reads the parameter RESET_CPSR, which defaults to 0x000000D3.
- R2: Mode encodings are 10000 User, 10001 FIQ, 10010 IRQ, 10011 SVC, 10111 Abort and 11011 Undefined. R0–R7 and R15 are one shared copy in every mode, and both read ports return the same value for the same index.
- R3: R8–R12 have a private copy in FIQ mode. All other modes share a second copy.
- R4: R13 and R14 have a private copy in each of FIQ, IRQ, SVC, Abort and Undefined. User mode uses the common copy.
- R5: The 26-bit encodings 00000, 00001, 00010 and 00011 select the same banks as User, FIQ, IRQ and SVC. Every other encoding selects the User banks.
- R6: A pulse on exc_take does the following on one edge. It copies the old CPSR into the target mode's SPSR (if that mode has one). It writes exc_ret_addr into the target mode's R14. It replaces CPSR[4:0] with exc_mode and leaves the other CPSR bits unchanged. Any register, CPSR or SPSR write requested in that same cycle is ignored.
- R7: Each privileged mode has its own SPSR. In the User banks, the SPSR reads zero and writes to it are ignored.
- R8: A read of a register that is being written in the same cycle returns the old value. The new value is visible after the edge.
- R9: A CPSR write replaces all 32 bits, including the flags N, Z, C, V in bits 31..28 and I, F in bits 7 and 6. The mode field selects the banks from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| cpsr_rdata | output | 32 | Current status word |
| cpsr_we | input | 1 | CPSR write enable |
| cpsr_wdata | input | 32 | CPSR write data |
| spsr_rdata | output | 32 | SPSR of the current mode |
| spsr_we | input | 1 | SPSR write enable |
| spsr_wdata | input | 32 | SPSR write data |
| exc_take | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode of the exception |
| exc_ret_addr | input | 32 | Return address written to the target R14 |

## Verification
A write-then-read sequence sets the mode and then writes or reads an index. It writes the same index under different modes and then reads it back under others. This separates the three sharing groups: R0–R7 plus R15, R8–R12, and R13/R14. Reads under 26-bit encodings and under an unused encoding show that aliasing and the User fallback pick the right bank, not just some bank. The SPSR is written with a distinct value in every privileged mode and in User mode, which exposes cross-bank writes and dropped User writes. An exception entry with competing writes in the same cycle shows which write wins.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    localparam int MODE_W    = 5;
    localparam int NUM_BANKS = 6;

endpackage

// File: rtl/rbank_mode_dec.sv
module rbank_mode_dec
    import rbank_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank
);

    always_comb begin
        unique case (mode)
            5'b10001, 5'b00001: bank = BANK_FIQ;
            5'b10010, 5'b00010: bank = BANK_IRQ;
            5'b10011, 5'b00011: bank = BANK_SVC;
            5'b10111:           bank = BANK_ABT;
            5'b11011:           bank = BANK_UND;
            default:            bank = BANK_USR;
        endcase
    end

endmodule

// File: rtl/rbank_map.sv
module rbank_map
    import rbank_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int PHYS_W  = 5,
    parameter int FIQ_LO  = 8,
    parameter int FIQ_CNT = 5
) (
    input  logic [IDX_W-1:0]  idx,
    input  bank_e             bank,
    output logic [PHYS_W-1:0] phys
);

    localparam int NUM_ARCH = 1 << IDX_W;
    localparam int SP_IDX   = NUM_ARCH - 3;
    localparam int FIQ_BASE = NUM_ARCH;
    localparam int HI_BASE  = FIQ_BASE + FIQ_CNT;

    always_comb begin
        int slot;
        slot = int'(idx);
        if (bank == BANK_FIQ && slot >= FIQ_LO && slot < FIQ_LO + FIQ_CNT)
            slot = FIQ_BASE + (slot - FIQ_LO);
        else if (bank != BANK_USR && (slot == SP_IDX || slot == SP_IDX + 1))
            slot = HI_BASE + 2 * (int'(bank) - 1) + (slot - SP_IDX);
        phys = PHYS_W'(slot);
    end

endmodule

// File: rtl/rbank_psr.sv
module rbank_psr
    import rbank_pkg::*;
#(
    parameter int          DW         = 32,
    parameter logic [31:0] RESET_CPSR = 32'h0000_00D3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             cur_bank,
    input  logic              cpsr_we,
    input  logic [DW-1:0]     cpsr_wdata,
    input  logic              spsr_we,
    input  logic [DW-1:0]     spsr_wdata,
    input  logic              exc_take,
    input  logic [MODE_W-1:0] exc_mode,
    input  bank_e             exc_bank,
    output logic [DW-1:0]     cpsr_q,
    output logic [DW-1:0]     spsr_rdata
);

    logic [DW-1:0] spsr_q [NUM_BANKS];

    // current status word: exception entry outranks a direct write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cpsr_q <= DW'(RESET_CPSR);
        else if (exc_take)
            cpsr_q <= {cpsr_q[DW-1:MODE_W], exc_mode};
        else if (cpsr_we)
            cpsr_q <= cpsr_wdata;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_spsr
        if (b == 0) begin : g_none
            assign spsr_q[b] = '0;
        end else begin : g_reg
            logic save_hit, wr_hit;
            assign save_hit = exc_take && (int'(exc_bank) == b);
            assign wr_hit   = !exc_take && spsr_we && (int'(cur_bank) == b);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    spsr_q[b] <= '0;
                else if (save_hit)
                    spsr_q[b] <= cpsr_q;
                else if (wr_hit)
                    spsr_q[b] <= spsr_wdata;
            end
        end
    end

    assign spsr_rdata = spsr_q[cur_bank];

    p_exc_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (cpsr_q[MODE_W-1:0] == $past(exc_mode)) &&
                     (cpsr_q[DW-1:MODE_W] == $past(cpsr_q[DW-1:MODE_W])));

    p_exc_spsr_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && exc_bank != BANK_USR) |=> spsr_rdata == $past(cpsr_q));

    p_cpsr_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr_we && !exc_take) |=> cpsr_q == $past(cpsr_wdata));

endmodule

// File: rtl/rbank_regfile.sv
module rbank_regfile
    import rbank_pkg::*;
#(
    parameter int          DW         = 32,
    parameter int          IDX_W      = 4,
    parameter logic [31:0] RESET_CPSR = 32'h0000_00D3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DW-1:0]     rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DW-1:0]     rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     cpsr_rdata,
    input  logic              cpsr_we,
    input  logic [DW-1:0]     cpsr_wdata,
    output logic [DW-1:0]     spsr_rdata,
    input  logic              spsr_we,
    input  logic [DW-1:0]     spsr_wdata,
    input  logic              exc_take,
    input  logic [MODE_W-1:0] exc_mode,
    input  logic [DW-1:0]     exc_ret_addr
);

    localparam int NUM_ARCH = 1 << IDX_W;
    localparam int FIQ_LO   = 8;
    localparam int FIQ_CNT  = 5;
    localparam int NPHYS    = NUM_ARCH + FIQ_CNT + 2 * (NUM_BANKS - 1);
    localparam int PHYS_W   = $clog2(NPHYS);
    localparam logic [IDX_W-1:0] LR_IDX = IDX_W'(NUM_ARCH - 2);

    bank_e             cur_bank, exc_bank;
    logic [DW-1:0]     cpsr_q;
    logic [PHYS_W-1:0] rd_a_phys, rd_b_phys, wr_phys, lr_phys;
    logic [DW-1:0]     regs [NPHYS];

    rbank_mode_dec u_dec_cur (.mode(cpsr_q[MODE_W-1:0]), .bank(cur_bank));
    rbank_mode_dec u_dec_exc (.mode(exc_mode),           .bank(exc_bank));

    rbank_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W), .FIQ_LO(FIQ_LO), .FIQ_CNT(FIQ_CNT))
        u_map_a  (.idx(rd_a_idx), .bank(cur_bank), .phys(rd_a_phys));
    rbank_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W), .FIQ_LO(FIQ_LO), .FIQ_CNT(FIQ_CNT))
        u_map_b  (.idx(rd_b_idx), .bank(cur_bank), .phys(rd_b_phys));
    rbank_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W), .FIQ_LO(FIQ_LO), .FIQ_CNT(FIQ_CNT))
        u_map_w  (.idx(wr_idx),   .bank(cur_bank), .phys(wr_phys));
    rbank_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W), .FIQ_LO(FIQ_LO), .FIQ_CNT(FIQ_CNT))
        u_map_lr (.idx(LR_IDX),   .bank(exc_bank), .phys(lr_phys));

    rbank_psr #(.DW(DW), .RESET_CPSR(RESET_CPSR)) u_psr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_bank   (cur_bank),
        .cpsr_we    (cpsr_we),
        .cpsr_wdata (cpsr_wdata),
        .spsr_we    (spsr_we),
        .spsr_wdata (spsr_wdata),
        .exc_take   (exc_take),
        .exc_mode   (exc_mode),
        .exc_bank   (exc_bank),
        .cpsr_q     (cpsr_q),
        .spsr_rdata (spsr_rdata)
    );

    for (genvar p = 0; p < NPHYS; p++) begin : g_reg
        logic lr_hit, wr_hit;
        assign lr_hit = exc_take && (lr_phys == PHYS_W'(p));
        assign wr_hit = !exc_take && wr_en && (wr_phys == PHYS_W'(p));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[p] <= '0;
            else if (lr_hit)
                regs[p] <= exc_ret_addr;
            else if (wr_hit)
                regs[p] <= wr_data;
        end
    end

    assign rd_a_data  = regs[rd_a_phys];
    assign rd_b_data  = regs[rd_b_phys];
    assign cpsr_rdata = cpsr_q;

    p_ports_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

    p_user_spsr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bank == BANK_USR) |-> (spsr_rdata == '0));

    p_write_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exc_take && !cpsr_we) |=>
            (rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data)));

    p_exc_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (rd_a_idx != LR_IDX) || (rd_a_data == $past(exc_ret_addr)));

endmodule

// File: tb/tb_rbank_regfile.sv
module tb_rbank_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, cpsr_rdata, spsr_rdata;
    logic        wr_en = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0, exc_take = 1'b0;
    logic [31:0] wr_data = '0, cpsr_wdata = '0, spsr_wdata = '0, exc_ret_addr = '0;
    logic [4:0]  exc_mode = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rbank_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cpsr_rdata(cpsr_rdata), .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata),
        .spsr_rdata(spsr_rdata), .spsr_we(spsr_we), .spsr_wdata(spsr_wdata),
        .exc_take(exc_take), .exc_mode(exc_mode), .exc_ret_addr(exc_ret_addr)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  mode;
        logic [3:0]  idx;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'b10000, 4'd8,  32'h0000A008},  // R3 user R8
        '{1'b1, 5'b10001, 4'd8,  32'h0000F008},  // R3 fiq R8
        '{1'b0, 5'b10000, 4'd8,  32'h0000A008},  // R3
        '{1'b0, 5'b00001, 4'd8,  32'h0000F008},  // R5 fiq26 alias
        '{1'b0, 5'b10010, 4'd8,  32'h0000A008},  // R3 irq shares
        '{1'b1, 5'b10011, 4'd13, 32'h00005013},  // R4
        '{1'b1, 5'b10010, 4'd13, 32'h00001013},
        '{1'b1, 5'b10111, 4'd13, 32'h0000AB13},
        '{1'b1, 5'b11011, 4'd13, 32'h0000D013},
        '{1'b1, 5'b10000, 4'd13, 32'h00000013},
        '{1'b0, 5'b00011, 4'd13, 32'h00005013},  // R5 svc26
        '{1'b0, 5'b00010, 4'd13, 32'h00001013},  // R5 irq26
        '{1'b0, 5'b10111, 4'd13, 32'h0000AB13},  // R4 abt
        '{1'b0, 5'b11011, 4'd13, 32'h0000D013},  // R4 und
        '{1'b0, 5'b00000, 4'd13, 32'h00000013},  // R5 usr26
        '{1'b0, 5'b11111, 4'd13, 32'h00000013},  // R5 unknown -> user
        '{1'b1, 5'b10001, 4'd3,  32'h00003333},  // R2
        '{1'b0, 5'b11011, 4'd3,  32'h00003333},  // R2 shared low
        '{1'b1, 5'b10111, 4'd15, 32'h15150000},  // R2 pc
        '{1'b0, 5'b10001, 4'd15, 32'h15150000},  // R2 pc shared
        '{1'b0, 5'b10001, 4'd13, 32'h00000000},  // R4 fiq R13 untouched
        '{1'b1, 5'b10001, 4'd14, 32'h0000F014},  // R4
        '{1'b0, 5'b10000, 4'd14, 32'h00000000}   // R4 user R14 separate
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_mode(input logic [4:0] m, input logic [26:0] upper = '0);
        @(negedge clk);
        cpsr_we = 1'b1;
        cpsr_wdata = {upper[26:3], 3'b110, m};
        @(negedge clk);
        cpsr_we = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cpsr reset", cpsr_rdata, 32'h000000D3);
        check("R1 spsr reset", spsr_rdata, 32'h0);
        rd_a_idx = 4'd0; rd_b_idx = 4'd14;
        #1;
        check("R1 r0 reset", rd_a_data, 32'h0);
        check("R1 r14 reset", rd_b_data, 32'h0);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            set_mode(VECS[i].mode);
            if (VECS[i].wr) begin
                wr_en = 1'b1; wr_idx = VECS[i].idx; wr_data = VECS[i].data;
                @(negedge clk);
                wr_en = 1'b0;
            end else begin
                rd_a_idx = VECS[i].idx; rd_b_idx = VECS[i].idx;
                #1;
                check($sformatf("R2/R3/R4/R5 vec %0d port a", i), rd_a_data, VECS[i].data);
                check($sformatf("R2 vec %0d port b", i), rd_b_data, VECS[i].data);
            end
        end

        // R9 CPSR flags and mode field
        @(negedge clk);
        cpsr_we = 1'b1; cpsr_wdata = 32'hF00000D1;
        @(negedge clk);
        cpsr_we = 1'b0;
        check("R9 cpsr flags", cpsr_rdata, 32'hF00000D1);
        rd_a_idx = 4'd8; #1;
        check("R9 new mode selects fiq bank", rd_a_data, 32'h0000F008);

        // R7 SPSR per privileged mode
        set_mode(5'b10011); spsr_we = 1'b1; spsr_wdata = 32'h11; @(negedge clk); spsr_we = 1'b0;
        set_mode(5'b10010); spsr_we = 1'b1; spsr_wdata = 32'h22; @(negedge clk); spsr_we = 1'b0;
        set_mode(5'b10111); spsr_we = 1'b1; spsr_wdata = 32'h33; @(negedge clk); spsr_we = 1'b0;
        set_mode(5'b11011); spsr_we = 1'b1; spsr_wdata = 32'h44; @(negedge clk); spsr_we = 1'b0;
        set_mode(5'b10001); spsr_we = 1'b1; spsr_wdata = 32'h55; @(negedge clk); spsr_we = 1'b0;
        set_mode(5'b10000); spsr_we = 1'b1; spsr_wdata = 32'h99; @(negedge clk); spsr_we = 1'b0;
        check("R7 user spsr reads zero", spsr_rdata, 32'h0);
        set_mode(5'b10011); check("R7 svc spsr", spsr_rdata, 32'h11);
        set_mode(5'b10010); check("R7 irq spsr", spsr_rdata, 32'h22);
        set_mode(5'b10111); check("R7 abt spsr", spsr_rdata, 32'h33);
        set_mode(5'b11011); check("R7 und spsr", spsr_rdata, 32'h44);
        set_mode(5'b00001); check("R7 fiq26 spsr", spsr_rdata, 32'h55);

        // R8 read during write
        set_mode(5'b10000);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h000055AA; rd_a_idx = 4'd5;
        #1;
        check("R8 old value during write", rd_a_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R8 new value after edge", rd_a_data, 32'h000055AA);

        // R6 exception entry with competing writes
        set_mode(5'b10000, 27'h1000000);   // cpsr = 0x200000D0
        check("R6 pre cpsr", cpsr_rdata, 32'h200000D0);
        @(negedge clk);
        exc_take = 1'b1; exc_mode = 5'b10010; exc_ret_addr = 32'hCAFE0004;
        wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h00000BAD;
        cpsr_we = 1'b1; cpsr_wdata = 32'h00000BAD;
        spsr_we = 1'b1; spsr_wdata = 32'h00000BAD;
        @(negedge clk);
        exc_take = 1'b0; wr_en = 1'b0; cpsr_we = 1'b0; spsr_we = 1'b0;
        rd_a_idx = 4'd14; rd_b_idx = 4'd0;
        #1;
        check("R6 cpsr mode replaced", cpsr_rdata, 32'h200000D2);
        check("R6 spsr saved", spsr_rdata, 32'h200000D0);
        check("R6 link written", rd_a_data, 32'hCAFE0004);
        check("R6 competing reg write ignored", rd_b_data, 32'h0);
        set_mode(5'b10000);
        check("R6 user r14 untouched", rd_a_data, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule